// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Reset-Selected Write Mode

This block buffers 9-bit words between a write clock domain and a read clock domain that may be unrelated or may be the same clock. Words enter through a write port gated by an active-low primary write enable. They leave through a registered output that advances only when two active-low read enables are both asserted. Two active-low flags report the state of the buffer. The full flag belongs to the write clock and the empty flag belongs to the read clock. An active-low output enable either drives the output register onto the data bus or releases the bus to high impedance.

One input has two uses. The level on `wr_en2_ld` while reset is held is captured as the write mode. If the level is high, the pin becomes a second write enable, active high, for depth expansion. If the level is low, the part is in load-strobe mode. In that mode the primary enable alone gates writes, and the pin is left to a separate offset-loading block. Read and write pointers cross between the domains as Gray code through two-flop synchronisers. Because of this, a flag clears a few cycles late but never clears early. The storage depth is `2**ADDR_W` words.

Top module: `dual_clock_word_fifo`

## Requirements
- R1: While `rst_n` is low, `full_n` is 1, `empty_n` is 0 and the output register is zero. With `oe_n` low, `rd_q` reads 0 after reset.
- R2: On a rising `rd_clk` edge where `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1, the oldest stored word is loaded into the output register.
- R3: On a read edge where either read enable is 1, the output register keeps its value and no word is consumed.
- R4: On a read edge where `empty_n` is 0, the read enables have no effect and the output register keeps its value.
- R5: If `wr_en2_ld` is 1 during reset (dual-enable mode), a word is stored only on a `wr_clk` edge with `wr_en1_n` = 0 and `wr_en2_ld` = 1.
- R6: If `wr_en2_ld` is 0 during reset (load-strobe mode), a word is stored on every `wr_clk` edge with `wr_en1_n` = 0, whatever the level of `wr_en2_ld`.
- R7: `full_n` falls on the write edge that stores the `2**ADDR_W`-th unread word. While `full_n` is 0, writes are ignored. `full_n` rises again no later than the fourth `wr_clk` edge after a read, when both clocks are one clock.
- R8: `empty_n` falls on the read edge that removes the last word. `empty_n` rises no later than the fourth `rd_clk` edge after a write, when both clocks are one clock.
- R9: With `oe_n` = 1, the bus `rd_q` is released to high impedance. With `oe_n` = 0, it carries the output register.
- R10: Words come out in the order they were written, including across pointer wrap-around.
- R11: The write mode captured at reset does not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_data | input | DATA_W | Word to store |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Mode select during reset; second write enable (active high) in dual-enable mode |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output bus enable, active low |
| rd_q | output | DATA_W | Output data bus, high impedance when disabled |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |

## Verification
The bench targets the points where a flawed FIFO would go wrong:
- Filling to exactly the depth: a wrong full comparison either loses the last word or overwrites the oldest one.
- Writing once more while full: an unguarded pointer would advance and corrupt the order.
- Holding just one read enable low: a design that ORs the enables would consume a word.
- Reading while empty: a design that ignores the flag would replay stale storage.
- Driving the dual-purpose pin low with the primary enable low, under both captured modes: it checks that this level blocks writes only in dual-enable mode.
- Sweeping burst lengths across repeated pointer wrap: a binary pointer that skips the Gray crossing, or a wrong wrap bit, shows up as reordered data or a stuck flag.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      srst_n <= stage1;
    end
  end
endmodule

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en1_n,
  input  logic              en2_ld,
  input  logic [PW-1:0]     rgray_s,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     wgray,
  output logic              full_n
);
  localparam logic [PW-1:0] DEPTH = PW'(1 << ADDR_W);

  logic          dual_mode;
  logic          wr_gate;
  logic [PW-1:0] wbin, wbin_nxt, wgray_nxt, full_match;
  logic [PW-1:0] rbin_s, occupancy;

  // mode is sampled continuously while the domain reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) dual_mode <= en2_ld;
  end

  assign wr_gate    = dual_mode ? (!en1_n && en2_ld) : !en1_n;
  assign wr_fire    = wr_gate && full_n;
  assign wbin_nxt   = wbin + {{ADDR_W{1'b0}}, wr_fire};
  assign wgray_nxt  = PW'(to_gray(32'(wbin_nxt)));
  assign full_match = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
  assign waddr      = wbin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
    end else begin
      wbin   <= wbin_nxt;
      wgray  <= wgray_nxt;
      full_n <= (wgray_nxt != full_match);
    end
  end

  assign rbin_s    = PW'(from_gray(32'(rgray_s)));
  assign occupancy = wbin - rbin_s;

  assert_hold_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= DEPTH);
  assert_mode_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(dual_mode));
  assert_dual_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && !en2_ld) |=> $stable(wbin));
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en1_n,
  input  logic              en2_n,
  input  logic [PW-1:0]     wgray_s,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rgray,
  output logic              empty_n
);
  logic          rd_gate;
  logic [PW-1:0] rbin, rbin_nxt, rgray_nxt;

  assign rd_gate   = !en1_n && !en2_n;
  assign rd_fire   = rd_gate && empty_n;
  assign rbin_nxt  = rbin + {{ADDR_W{1'b0}}, rd_fire};
  assign rgray_nxt = PW'(to_gray(32'(rbin_nxt)));
  assign raddr     = rbin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= rgray_nxt;
      empty_n <= (rgray_nxt != wgray_s);
    end
  end

  assert_ignore_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));
  assert_single_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_n || en2_n) |=> $stable(rbin));
endmodule

// File: rtl/dual_clock_word_fifo.sv
module dual_clock_word_fifo #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en1_n,
  input  logic              wr_en2_ld,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_q,
  output logic              full_n,
  output logic              empty_n
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wrst_n, rrst_n;
  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] q_reg;
  logic [DATA_W-1:0] store [DEPTH];

  fifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  fifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  fifo_gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  fifo_gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  fifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .en1_n(wr_en1_n), .en2_ld(wr_en2_ld),
    .rgray_s(rgray_s), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .full_n(full_n)
  );

  fifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .wgray_s(wgray_s), .rd_fire(rd_fire), .raddr(raddr), .rgray(rgray),
    .empty_n(empty_n)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_fire) store[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n)      q_reg <= '0;
    else if (rd_fire) q_reg <= store[raddr];
  end

  assign rd_q = oe_n ? {DATA_W{1'bz}} : q_reg;

  assert_q_holds_R3: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_en1_n || rd_en2_n) |=> $stable(q_reg));
  assert_q_empty_hold_R4: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !empty_n |=> $stable(q_reg));
endmodule

// File: tb/dual_clock_word_fifo_tb.sv
module dual_clock_word_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
  logic       rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
  logic [8:0] rd_q;
  logic       full_n, empty_n;

  int checks = 0, fails = 0;
  int model[$];
  int last_q = 0;
  bit dual = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clock_word_fifo #(.DATA_W(9), .ADDR_W(AW)) u_dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .oe_n(oe_n), .rd_q(rd_q), .full_n(full_n),
    .empty_n(empty_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit mode_level);
    @(negedge clk);
    rst_n = 1'b0; wr_en2_ld = mode_level; wr_en1_n = 1'b1;
    rd_en1_n = 1'b1; rd_en2_n = 1'b1; oe_n = 1'b0;
    settle(2);
    // R1: flag and output state while reset is held
    check(full_n == 1'b1, "R1 full_n in reset", full_n, 1);
    check(empty_n == 1'b0, "R1 empty_n in reset", empty_n, 0);
    check(rd_q == 9'd0, "R1 output register zero", rd_q, 0);
    settle(2);
    rst_n = 1'b1;
    settle(5);
    dual = mode_level;
    model.delete();
    last_q = 0;
  endtask

  task automatic write_word(input int d, input bit e1n, input bit e2);
    wr_data = 9'(d); wr_en1_n = e1n; wr_en2_ld = e2;
    if ((dual ? (!e1n && e2) : !e1n) && model.size() < DEPTH) model.push_back(d & 9'h1FF);
    @(negedge clk);
    wr_en1_n = 1'b1;
  endtask

  task automatic read_word(input bit r1n, input bit r2n, input string req);
    int exp;
    rd_en1_n = r1n; rd_en2_n = r2n;
    if (!r1n && !r2n && model.size() > 0) begin
      exp = model.pop_front();
      last_q = exp;
    end else exp = last_q;
    @(negedge clk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    check(rd_q == 9'(exp), req, rd_q, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // dual-enable mode
    do_reset(1'b1);
    write_word(9'h055, 1'b0, 1'b0);             // R5: second enable low blocks
    settle(4);
    check(empty_n == 1'b0, "R5 write blocked by wr_en2_ld low", empty_n, 0);
    write_word(9'h101, 1'b0, 1'b1);
    settle(4);
    check(empty_n == 1'b1, "R8 empty_n rises after write", empty_n, 1);
    write_word(9'h0A2, 1'b0, 1'b1);
    write_word(9'h1F3, 1'b0, 1'b1);
    settle(4);
    read_word(1'b0, 1'b1, "R3 only first read enable low");
    read_word(1'b1, 1'b0, "R3 only second read enable low");
    read_word(1'b0, 1'b0, "R2 first word out");
    oe_n = 1'b1;
    #1;
    check(rd_q !== 9'h101, "R9 bus released with oe_n high", rd_q, 0);
    oe_n = 1'b0;
    #1;
    check(rd_q == 9'h101, "R9 bus driven with oe_n low", rd_q, 32'h101);
    read_word(1'b0, 1'b0, "R2 second word out");
    read_word(1'b0, 1'b0, "R2 third word out");
    check(empty_n == 1'b0, "R8 empty_n falls on last read", empty_n, 0);
    read_word(1'b0, 1'b0, "R4 read while empty holds output");
    check(model.size() == 0, "R5 only enabled writes stored", model.size(), 0);

    // load-strobe mode
    do_reset(1'b0);
    write_word(9'h011, 1'b0, 1'b0);             // R6: accepted with pin low
    write_word(9'h022, 1'b0, 1'b1);
    write_word(9'h033, 1'b1, 1'b1);             // not enabled
    settle(4);
    read_word(1'b0, 1'b0, "R6 write with pin low stored");
    read_word(1'b0, 1'b0, "R6 write with pin high stored");
    check(empty_n == 1'b0, "R6 disabled write not stored", empty_n, 0);
    wr_en2_ld = 1'b1;                           // R11: pin change after reset keeps mode
    settle(2);
    write_word(9'h044, 1'b0, 1'b0);
    settle(4);
    read_word(1'b0, 1'b0, "R11 mode unchanged after reset");

    // fill to depth
    settle(4);
    for (int i = 0; i < DEPTH; i++) begin
      check(full_n == 1'b1, "R7 full_n high before depth", full_n, 1);
      write_word(9'h100 + i * 3, 1'b0, 1'b0);
    end
    check(full_n == 1'b0, "R7 full_n low at depth", full_n, 0);
    write_word(9'h1AA, 1'b0, 1'b0);             // ignored, model also full
    settle(4);
    read_word(1'b0, 1'b0, "R10 first of full buffer");
    settle(4);
    check(full_n == 1'b1, "R7 full_n rises after read", full_n, 1);
    for (int i = 1; i < DEPTH; i++) read_word(1'b0, 1'b0, "R10 full buffer order");
    check(empty_n == 1'b0, "R7 overflow word not stored", empty_n, 0);

    // burst sweep across wrap
    for (int round = 0; round < 3; round++) begin
      for (int k = 1; k <= DEPTH; k++) begin
        for (int i = 0; i < k; i++) write_word(round * 97 + k * 13 + i * 5, 1'b0, 1'b1);
        settle(4);
        for (int i = 0; i < k; i++) read_word(1'b0, 1'b0, "R10 wrap order");
        check(empty_n == 1'b0, "R8 empty after burst", empty_n, 0);
        settle(4);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule